// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Threshold Interrupts

This block holds the data path and event logic that sit between a register bus and an SPI shift engine. It has two byte-wide FIFOs. Software fills the transmit FIFO through a data register and the shift engine takes bytes from its head. The shift engine fills the receive FIFO and software empties it through a second data register. Each FIFO has its own 8-bit trigger level. The levels and two flush controls live in one control word. A fill-count word reports how full each FIFO is.

Four events are latched in a status word: receive ready, transmit request, receive overflow and transfer complete. An enable word uses the same bit positions as the status word. Software clears status bits by writing ones. The single interrupt output is high while any enabled status bit is set. The shift engine, clock generation and DMA are outside this block.

Register map, selected by the 3-bit word address: 0 control, 1 fill counts (read only), 2 interrupt enable, 3 interrupt status (write one to clear), 4 transmit data (write pushes), 5 receive data (read pops). Reads are combinational.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset both fill counts, the status word, the enable word and the control word read zero, and `irq` and `tx_avail` are low.
- R2: Bytes written to address 4 leave at `tx_byte` in the order written, one per `tx_pop` cycle. `tx_avail` is high while the transmit FIFO is not empty. A write to a full transmit FIFO is dropped.
- R3: Bytes pushed with `rx_push` are read back from address 5 in the order pushed. A read of address 5 while the receive FIFO is empty returns zero.
- R4: Address 1 returns the receive fill count starting at bit 0 and the transmit fill count starting at bit 16. Each field is wide enough to hold a count equal to DEPTH.
- R5: In the control word, bits 7:0 hold the receive trigger level and bits 23:16 hold the transmit trigger level, and both read back as written. Writing a one to bit 15 empties the receive FIFO. Writing a one to bit 31 empties the transmit FIFO. Bits 15 and 31 always read zero.
- R6: Status bit 0 (receive ready) is set in the cycle after the receive fill count is at or above the receive trigger level.
- R7: Status bit 4 (transmit request) is set in the cycle after the transmit fill count is at or below the transmit trigger level.
- R8: A push into a full receive FIFO sets status bit 8 (receive overflow). The pushed byte is dropped and the stored bytes and the count are unchanged.
- R9: A one-cycle `xfer_done` pulse sets status bit 12 (transfer complete).
- R10: Writing ones to address 3 clears the selected status bits, and writing all ones clears every bit. In the cycle of the write, the clear wins over a new set. A level condition that still holds sets its bit again one cycle later.
- R11: `irq` is high exactly when some status bit is set whose enable bit at the same position in the enable word (bits 0, 4, 8, 12) is also set. Other enable bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 5) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tx_pop | input | 1 | Shift engine takes the transmit head byte |
| tx_byte | output | 8 | Transmit FIFO head byte |
| tx_avail | output | 1 | Transmit FIFO not empty |
| rx_push | input | 1 | Shift engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| xfer_done | input | 1 | Transfer finished pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 8. This makes both FIFOs small enough to fill completely within a few dozen cycles. Full-count reporting, dropped writes to a full transmit FIFO and receive overflow can therefore all be reached directly. With a receive level of 6 and a transmit level of 2, each threshold can be crossed from both sides within the same short sequences. A scoreboard queue checks byte order through each FIFO, including the byte that overflow drops.

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq #(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_avail,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        xfer_done,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_FCNT = 3'd1, A_IEN = 3'd2,
                         A_ISTS = 3'd3, A_TXD = 3'd4, A_RXD = 3'd5;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    rx_lvl, tx_lvl;
  logic [3:0]    st, en, set, clr;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire tx_flush = wr_ctrl && reg_wdata[31];
  wire rx_flush = wr_ctrl && reg_wdata[15];
  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire tx_in    = reg_wr && reg_addr == A_TXD && !tx_full;
  wire tx_out   = tx_pop && tx_cnt != '0;
  wire rx_in    = rx_push && !rx_full;
  wire rx_out   = reg_rd && reg_addr == A_RXD && rx_cnt != '0;

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_in) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_in)  tx_wp <= tx_wp + 1'b1;
      if (tx_out) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_in)  rx_wp <= rx_wp + 1'b1;
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  assign set = {xfer_done, rx_push && rx_full,
                32'(tx_cnt) <= 32'(tx_lvl), 32'(rx_cnt) >= 32'(rx_lvl)};
  assign clr = (reg_wr && reg_addr == A_ISTS) ?
               {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]} : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_lvl <= '0; tx_lvl <= '0; st <= '0; en <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_lvl <= reg_wdata[7:0];
        tx_lvl <= reg_wdata[23:16];
      end
      if (reg_wr && reg_addr == A_IEN)
        en <= {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]};
      st <= (st | set) & ~clr;
    end
  end

  function automatic logic [31:0] spread(input logic [3:0] b);
    return {19'b0, b[3], 3'b0, b[2], 3'b0, b[1], 3'b0, b[0]};
  endfunction

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {8'b0, tx_lvl, 8'b0, rx_lvl};
      A_FCNT:  reg_rdata = 32'(rx_cnt) | (32'(tx_cnt) << 16);
      A_IEN:   reg_rdata = spread(en);
      A_ISTS:  reg_rdata = spread(st);
      A_RXD:   reg_rdata = rx_cnt != '0 ? {24'b0, rx_mem[rx_rp]} : 32'b0;
      default: reg_rdata = 32'b0;
    endcase
  end

  assign tx_byte  = tx_mem[tx_rp];
  assign tx_avail = tx_cnt != '0;
  assign irq      = |(st & en);
endmodule

module spi_fifo_irq_chk #(
  parameter int DEPTH = 128,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          rx_push,
  input logic          xfer_done,
  input logic          irq,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [3:0]    st,
  input logic [3:0]    en
);
  wire sts_wr = reg_wr && reg_addr == 3'd3;

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH) && tx_cnt <= CW'(DEPTH));
  p_tx_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd0 && reg_wdata[31] |=> tx_cnt == '0);
  p_ctrl_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 3'd0 |-> !reg_rdata[15] && !reg_rdata[31]);
  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_cnt == CW'(DEPTH) && !(sts_wr && reg_wdata[8]) |=> st[2]);
  p_ovf_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_cnt == CW'(DEPTH) && !(reg_rd && reg_addr == 3'd5)
    && !(reg_wr && reg_addr == 3'd0 && reg_wdata[15]) |=> rx_cnt == CW'(DEPTH));
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !(sts_wr && reg_wdata[12]) |=> st[3]);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && reg_wdata[0] |=> !st[0]);
  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en == 4'b0 |-> !irq);
endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .rx_push(rx_push), .xfer_done(xfer_done), .irq(irq),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .st(st), .en(en));

// File: tb/tb_spi_fifo_irq.sv
module tb_spi_fifo_irq;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, tx_pop = 0, rx_push = 0, xfer_done = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0] tx_byte, rx_byte = 0;
  logic tx_avail, irq;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] txq[$], rxq[$];

  always #10 clk = ~clk;

  spi_fifo_irq #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic drv_tx(input logic [7:0] b, input bit keep);
    if (keep) txq.push_back(b);
    wr(3'd4, {24'b0, b});
  endtask

  task automatic drv_rx(input logic [7:0] b, input bit keep);
    if (keep) rxq.push_back(b);
    rx_push = 1; rx_byte = b;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic mon_tx();
    logic [7:0] e;
    while (txq.size() > 0) begin
      e = txq.pop_front();
      #1 chk("R2 tx order", tx_byte, e);
      tx_pop = 1; @(negedge clk); tx_pop = 0;
    end
  endtask

  task automatic mon_rx();
    logic [31:0] d;
    logic [7:0] e;
    while (rxq.size() > 0) begin
      e = rxq.pop_front();
      rd(3'd5, d);
      chk("R3 rx order", d, {24'b0, e});
    end
  endtask

  initial begin
    logic [31:0] d;
    idle(2); rst_n = 1;
    peek(3'd1, d); chk("R1 counts", d, 0);
    peek(3'd3, d); chk("R1 status", d, 0);
    peek(3'd2, d); chk("R1 enable", d, 0);
    peek(3'd0, d); chk("R1 control", d, 0);
    chk("R1 irq", irq, 0); chk("R1 tx_avail", tx_avail, 0);

    wr(3'd0, 32'h8002_8006);
    peek(3'd0, d); chk("R5 levels readback", d, 32'h0002_0006);
    wr(3'd2, 32'hFFFF_FFFF);
    peek(3'd2, d); chk("R11 enable bits", d, 32'h0000_1111);
    wr(3'd2, 0);
    wr(3'd3, 32'hFFFF_FFFF); idle(1);
    peek(3'd3, d); chk("R7 request while empty", d[4], 1);
    chk("R10 rx ready stays clear", d[0], 0);

    drv_tx(8'h11, 1); drv_tx(8'h22, 1); drv_tx(8'h33, 1);
    wr(3'd3, 32'h10);
    peek(3'd3, d); chk("R10 request cleared", d[4], 0);
    idle(1);
    peek(3'd3, d); chk("R7 no request above level", d[4], 0);
    for (int i = 0; i < 5; i++) drv_tx(8'h40 + 8'(i), 1);
    drv_tx(8'hEE, 0);
    peek(3'd1, d); chk("R4 tx full count", d, 32'h0008_0000);
    chk("R2 tx_avail", tx_avail, 1);
    mon_tx();
    chk("R2 tx_avail empty", tx_avail, 0);

    for (int i = 0; i < 5; i++) drv_rx(8'hA0 + 8'(i), 1);
    idle(1);
    peek(3'd3, d); chk("R6 below level", d[0], 0);
    drv_rx(8'hA5, 1); idle(1);
    peek(3'd3, d); chk("R6 at level", d[0], 1);
    wr(3'd3, 32'h1);
    peek(3'd3, d); chk("R10 clear wins", d[0], 0);
    idle(1);
    peek(3'd3, d); chk("R10 level resets bit", d[0], 1);
    drv_rx(8'hA6, 1); drv_rx(8'hA7, 1);
    peek(3'd3, d); chk("R8 no overflow yet", d[8], 0);
    drv_rx(8'hEE, 0);
    peek(3'd3, d); chk("R8 overflow set", d[8], 1);
    peek(3'd1, d); chk("R4 R8 rx full count", d, 32'h0000_0008);
    mon_rx();
    rd(3'd5, d); chk("R3 empty read", d, 0);

    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd2, 32'h1000);
    chk("R11 irq off", irq, 0);
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    peek(3'd3, d); chk("R9 done bit", d[12], 1);
    chk("R11 irq on", irq, 1);
    wr(3'd2, 32'h0);
    chk("R11 irq masked", irq, 0);
    wr(3'd3, 32'hFFFF_FFFF);
    peek(3'd3, d); chk("R10 all cleared", d & 32'h1100, 0);

    drv_tx(8'h01, 0); drv_tx(8'h02, 0);
    drv_rx(8'h03, 0);
    wr(3'd0, 32'h8002_0006);
    peek(3'd1, d); chk("R5 tx flush", d, 32'h0000_0001);
    wr(3'd0, 32'h0002_8006);
    peek(3'd1, d); chk("R5 rx flush", d, 0);
    peek(3'd0, d); chk("R5 reset bits zero", d, 32'h0002_0006);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule